// File: doc/BRIEF.md
# Burst-of-two quad-rate SRAM device model

This block is a synthesizable device-side model of a synchronous static memory. It has a write data input and a read data output, and the two are separate. Both ports carry data on both clock edges, and every access moves a two-word burst. One address bus is time-shared within each clock period. The rising edge carries a read address and the following falling edge carries a write address. As a result, a single clock cycle can accept one read and one write.

Commands are active-low strobes. They are sampled only on the rising edge. The first write beat and its byte-lane mask arrive on the falling edge, together with the write address. The second beat and its mask arrive on the next rising edge, and the whole burst is committed to the array on that edge. A read that targets a burst still waiting to commit is served from the merged new data. Read words leave on the falling edge one and a half cycles after the address was taken, and on the rising edge that follows. A valid flag marks both beats. An echo clock lets a host capture the output. An idle output reports when no burst of either kind is in flight.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read and a write issued in the same cycle are both carried out. The read returns its two words and the write updates the array.
- R2: A read sampled on rising edge n drives word 0 on `rdata` from the falling edge after rising edge n+1, and word 1 from rising edge n+2. `rvalid` is high during exactly those two half-cycles.
- R3: The read address is taken from `addr` at the rising edge. The write address is taken from `addr` at the falling edge of the same cycle.
- R4: `rd_n` and `wr_n` are active-low and sampled only at the rising edge. A low level present only during the second half-cycle issues no command.
- R5: Write beat 0 and mask 0 are captured at the falling edge. Beat 1 and mask 1 are captured at the next rising edge, and both words are committed on that rising edge.
- R6: `wmask_n` is active-low per lane. Bit i covers `wdata[i*L +: L]`, where L = DATA_W/MASK_W. MASK_W is 1, 2 or 4 for widths 9, 18 or 36, and is 2 (nibble lanes) for width 8. A masked lane keeps its previous contents.
- R7: A read whose address equals the write address of the same cycle returns the new write data, merged lane by lane with the old contents according to both masks.
- R8: `idle` is low from the edge after a command is sampled until every outstanding read beat has been driven and every write has been committed.
- R9: Out of reset, `echo_clk` follows the clock and `echo_clk_n` is its complement. Both are low in reset.
- R10: While `rst_n` is low, no command is accepted, `rvalid` is low and `idle` is high.
- R11: Each address selects one whole two-word burst. The array holds 2**ADDR_W independent bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low, rising edge |
| wr_n | input | 1 | Write strobe, active low, rising edge |
| addr | input | ADDR_W | Read address (rising edge), write address (falling edge) |
| wdata | input | DATA_W | Write beat 0 (falling edge), beat 1 (rising edge) |
| wmask_n | input | MASK_W | Active-low lane mask for the beat on `wdata` |
| rdata | output | DATA_W | Read word 0 (low clock phase), word 1 (high clock phase) |
| rvalid | output | 1 | High while `rdata` carries a read word |
| echo_clk | output | 1 | Capture clock in step with `rdata` |
| echo_clk_n | output | 1 | Complement of `echo_clk` |
| idle | output | 1 | No read or write burst outstanding |

## Verification
The bench builds the block with DATA_W = 18 and ADDR_W = 4, which gives two 9-bit mask lanes and sixteen bursts. With two lanes, split masks can be applied: one lane on beat 0 and the other on beat 1, as well as fully masked writes. Each of these is observed through a later read. The small depth makes both end addresses, 0 and 15, cheap to reach. It also makes same-cycle read/write collisions on a shared address frequent enough to exercise the merge path.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

   // Number of write-mask lanes for a given data width.
   function automatic int mask_lanes(input int dw);
      return (dw == 8) ? 2 : (dw / 9);
   endfunction

   function automatic bit width_ok(input int dw);
      return (dw == 8) || (dw == 9) || (dw == 18) || (dw == 36);
   endfunction

endpackage

// File: rtl/qdr_b2_capture.sv
// Command and address capture on both clock edges.
module qdr_b2_capture #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 18,
   parameter int MASK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MASK_W-1:0] wmask_n,
   output logic              rd_go,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_go,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wbeat0,
   output logic [MASK_W-1:0] wmask0_n
);

   // first half: strobes and read address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_go   <= 1'b0;
         wr_go   <= 1'b0;
         rd_addr <= '0;
      end else begin
         rd_go   <= ~rd_n;
         wr_go   <= ~wr_n;
         rd_addr <= addr;
      end
   end

   // second half: write address, beat 0 and its mask
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr  <= '0;
         wbeat0   <= '0;
         wmask0_n <= '1;
      end else begin
         wr_addr  <= addr;
         wbeat0   <= wdata;
         wmask0_n <= wmask_n;
      end
   end

endmodule

// File: rtl/qdr_b2_store.sv
// Burst array with commit on the second write beat and same-cycle merge.
module qdr_b2_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 18,
   parameter int MASK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wbeat0,
   input  logic [MASK_W-1:0] wmask0_n,
   input  logic [DATA_W-1:0] wbeat1,
   input  logic [MASK_W-1:0] wmask1_n,
   output logic              rstage_v,
   output logic [DATA_W-1:0] rword0,
   output logic [DATA_W-1:0] rword1
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int LANE_W = DATA_W / MASK_W;

   logic [DATA_W-1:0] mem_lo [DEPTH];
   logic [DATA_W-1:0] mem_hi [DEPTH];

   logic [DATA_W-1:0] old_lo, old_hi, new_lo, new_hi;
   logic [DATA_W-1:0] arr_lo, arr_hi;
   logic              hit;

   assign old_lo = mem_lo[wr_addr];
   assign old_hi = mem_hi[wr_addr];
   assign arr_lo = mem_lo[rd_addr];
   assign arr_hi = mem_hi[rd_addr];

   for (genvar l = 0; l < MASK_W; l++) begin : g_lane
      assign new_lo[l*LANE_W +: LANE_W] = wmask0_n[l] ? old_lo[l*LANE_W +: LANE_W]
                                                      : wbeat0[l*LANE_W +: LANE_W];
      assign new_hi[l*LANE_W +: LANE_W] = wmask1_n[l] ? old_hi[l*LANE_W +: LANE_W]
                                                      : wbeat1[l*LANE_W +: LANE_W];
   end

   assign hit = wr_go && rd_go && (rd_addr == wr_addr);

   always_ff @(posedge clk) begin
      if (wr_go) begin
         mem_lo[wr_addr] <= new_lo;
         mem_hi[wr_addr] <= new_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rstage_v <= 1'b0;
         rword0   <= '0;
         rword1   <= '0;
      end else begin
         rstage_v <= rd_go;
         if (rd_go) begin
            rword0 <= hit ? new_lo : arr_lo;
            rword1 <= hit ? new_hi : arr_hi;
         end
      end
   end

   AST_MERGE_MATCHES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (rword0 == mem_lo[$past(rd_addr)]) && (rword1 == mem_hi[$past(rd_addr)])); // R7

endmodule

// File: rtl/qdr_b2_ddr_out.sv
// Double-rate read output, valid flag and echo clocks.
module qdr_b2_ddr_out #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rstage_v,
   input  logic [DATA_W-1:0] rword0,
   input  logic [DATA_W-1:0] rword1,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              echo_clk,
   output logic              echo_clk_n,
   output logic              out_busy
);

   logic              fall_v, rise_v;
   logic [DATA_W-1:0] fall_d, rise_d;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_v <= 1'b0;
         fall_d <= '0;
      end else begin
         fall_v <= rstage_v;
         fall_d <= rword0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_v <= 1'b0;
         rise_d <= '0;
      end else begin
         rise_v <= rstage_v;
         rise_d <= rword1;
      end
   end

   assign rdata      = clk ? rise_d : fall_d;
   assign rvalid     = clk ? rise_v : fall_v;
   assign echo_clk   = clk & rst_n;
   assign echo_clk_n = ~clk & rst_n;
   assign out_busy   = fall_v | rise_v;

   AST_SECOND_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rise_v == $past(fall_v)); // R2

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
   parameter  int DATA_W = 18,
   parameter  int ADDR_W = 6,
   localparam int MASK_W = qdr_b2_pkg::mask_lanes(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MASK_W-1:0] wmask_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              echo_clk,
   output logic              echo_clk_n,
   output logic              idle
);

   if (!qdr_b2_pkg::width_ok(DATA_W)) begin : g_bad_width
      $error("qdr_b2_sram: DATA_W must be 8, 9, 18 or 36");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_depth
      $error("qdr_b2_sram: ADDR_W out of range 1..12");
   end

   logic              rd_go, wr_go, rstage_v, out_busy;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] wbeat0, rword0, rword1;
   logic [MASK_W-1:0] wmask0_n;

   qdr_b2_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .wmask_n(wmask_n), .rd_go(rd_go), .rd_addr(rd_addr),
      .wr_go(wr_go), .wr_addr(wr_addr), .wbeat0(wbeat0), .wmask0_n(wmask0_n));

   qdr_b2_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_addr(rd_addr),
      .wr_go(wr_go), .wr_addr(wr_addr), .wbeat0(wbeat0), .wmask0_n(wmask0_n),
      .wbeat1(wdata), .wmask1_n(wmask_n), .rstage_v(rstage_v),
      .rword0(rword0), .rword1(rword1));

   qdr_b2_ddr_out #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .rstage_v(rstage_v), .rword0(rword0),
      .rword1(rword1), .rdata(rdata), .rvalid(rvalid), .echo_clk(echo_clk),
      .echo_clk_n(echo_clk_n), .out_busy(out_busy));

   assign idle = ~(rd_go | wr_go | rstage_v | out_busy);

   AST_READ_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |=> !idle); // R8
   AST_WRITE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> !idle); // R8
   AST_DATA_HAS_A_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rstage_v) |-> $past(!rd_n, 2)); // R4

endmodule

// File: tb/qdr_b2_sram_test.sv
module qdr_b2_sram_test;

   localparam int CLK_T = 10;
   localparam int DW = 18;
   localparam int AW = 4;
   localparam int MW = 2;
   localparam int LW = DW / MW;

   typedef struct packed {
      logic          rd;
      logic [AW-1:0] ra;
      logic          wr;
      logic [AW-1:0] wa;
      logic [DW-1:0] d0;
      logic [MW-1:0] m0;
      logic [DW-1:0] d1;
      logic [MW-1:0] m1;
      logic          jk;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'd0,  1'b1, 4'd3,  18'h11111, 2'b00, 18'h22222, 2'b00, 1'b0}, // R5 full burst
      '{1'b0, 4'd0,  1'b1, 4'd5,  18'h0AAAA, 2'b00, 18'h0BBBB, 2'b00, 1'b0},
      '{1'b1, 4'd3,  1'b1, 4'd4,  18'h33333, 2'b00, 18'h04444, 2'b00, 1'b0}, // R1 R3
      '{1'b1, 4'd5,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b1}, // R4 late strobes
      '{1'b1, 4'd3,  1'b1, 4'd3,  18'h3CDEF, 2'b10, 18'h2FFFF, 2'b01, 1'b0}, // R7 R6 merge
      '{1'b1, 4'd3,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b0}, // R5 committed
      '{1'b1, 4'd4,  1'b1, 4'd4,  18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11, 1'b0}, // R6 masked
      '{1'b1, 4'd5,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b1}, // R4
      '{1'b1, 4'd4,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b0}, // R6
      '{1'b1, 4'd5,  1'b1, 4'd5,  18'h12345, 2'b00, 18'h2ABCD, 2'b00, 1'b0}, // R7 full
      '{1'b0, 4'd0,  1'b1, 4'd4,  18'h00001, 2'b01, 18'h00002, 2'b10, 1'b0}, // R6 split
      '{1'b1, 4'd4,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b0}, // R6
      '{1'b0, 4'd0,  1'b1, 4'd15, 18'h15555, 2'b00, 18'h2AAAA, 2'b00, 1'b0}, // R11
      '{1'b1, 4'd15, 1'b1, 4'd0,  18'h00777, 2'b00, 18'h00888, 2'b00, 1'b0}, // R11 R1
      '{1'b1, 4'd0,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b0}, // R11
      '{1'b1, 4'd5,  1'b0, 4'd0,  18'h00000, 2'b00, 18'h00000, 2'b00, 1'b0}  // R4 no stray write
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [MW-1:0] wmask_n = '1;
   logic [DW-1:0] rdata;
   logic          rvalid, echo_clk, echo_clk_n, idle;

   int checks = 0;
   int errs = 0;
   int pcount = 0;
   logic [DW-1:0] pb1 = '0;
   logic [MW-1:0] pm1 = '1;
   logic [DW-1:0] mdl_lo [16];
   logic [DW-1:0] mdl_hi [16];
   logic          ev [256];
   logic [DW-1:0] e0 [256];
   logic [DW-1:0] e1 [256];

   qdr_b2_sram #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .wmask_n(wmask_n), .rdata(rdata), .rvalid(rvalid),
      .echo_clk(echo_clk), .echo_clk_n(echo_clk_n), .idle(idle));

   always #(CLK_T/2) clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // One command cycle: strobes and read address for the rising edge,
   // then write address and beat 0 for the falling edge.
   task automatic issue(input vec_t v);
      int slot;
      @(negedge clk);
      #2;
      rd_n = ~v.rd; wr_n = ~v.wr; addr = v.ra; wdata = pb1; wmask_n = pm1;
      slot = (pcount + 1) % 256;
      if (v.wr) begin
         for (int l = 0; l < MW; l++) begin
            if (!v.m0[l]) mdl_lo[v.wa][l*LW +: LW] = v.d0[l*LW +: LW];
            if (!v.m1[l]) mdl_hi[v.wa][l*LW +: LW] = v.d1[l*LW +: LW];
         end
      end
      if (v.rd) begin
         ev[slot] = 1'b1; e0[slot] = mdl_lo[v.ra]; e1[slot] = mdl_hi[v.ra];
      end
      @(posedge clk);
      #2;
      addr = v.wa; wdata = v.d0; wmask_n = v.m0;
      if (v.jk) begin rd_n = 1'b0; wr_n = 1'b0; end
      pb1 = v.d1; pm1 = v.m1;
   endtask

   localparam vec_t NOP = '{1'b0, 4'd0, 1'b0, 4'd0, 18'h0, 2'b00, 18'h0, 2'b00, 1'b0};

   // Output monitor: beat 1 in the high phase, beat 0 in the low phase.
   initial begin
      for (int i = 0; i < 256; i++) ev[i] = 1'b0;
      forever begin
         int n;
         @(posedge clk);
         pcount++;
         ev[(pcount + 3) % 256] = 1'b0;
         #3;
         n = (pcount + 254) % 256;
         check("R2", "rvalid high phase", {17'b0, rvalid}, {17'b0, ev[n]});
         if (ev[n] && rvalid) check("R2", "word 1", rdata, e1[n]);
         check("R9", "echo_clk high phase", {17'b0, echo_clk}, {17'b0, rst_n});
         @(negedge clk);
         #3;
         n = (pcount + 255) % 256;
         check("R2", "rvalid low phase", {17'b0, rvalid}, {17'b0, ev[n]});
         if (ev[n] && rvalid) check("R2", "word 0", rdata, e0[n]);
         check("R9", "echo_clk_n low phase", {17'b0, echo_clk_n}, {17'b0, rst_n});
      end
   end

   initial begin
      #(CLK_T * 50000);
      errs++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

   initial begin
      // R10: commands driven during reset are ignored
      rd_n = 1'b0; wr_n = 1'b0; addr = 4'd3;
      repeat (4) begin
         @(posedge clk); #3;
         check("R10", "idle in reset", {17'b0, idle}, 18'd1);
         check("R9", "echo_clk low in reset", {17'b0, echo_clk}, 18'd0);
      end
      @(negedge clk); #2;
      rd_n = 1'b1; wr_n = 1'b1;
      rst_n = 1'b1;
      issue(NOP);
      issue(NOP);
      check("R10", "idle after reset", {17'b0, idle}, 18'd1);

      for (int i = 0; i < NV; i++) issue(VECS[i]);
      repeat (4) issue(NOP);

      // R8: read drains over three edges
      issue('{1'b1, 4'd5, 1'b0, 4'd0, 18'h0, 2'b00, 18'h0, 2'b00, 1'b0});
      check("R8", "idle after read sampled", {17'b0, idle}, 18'd0);
      issue(NOP);
      check("R8", "idle, read staged", {17'b0, idle}, 18'd0);
      issue(NOP);
      check("R8", "idle, beats out", {17'b0, idle}, 18'd0);
      issue(NOP);
      check("R8", "idle after drain", {17'b0, idle}, 18'd1);

      // R8: write is outstanding until its commit edge
      issue('{1'b0, 4'd0, 1'b1, 4'd9, 18'h1F0F0, 2'b00, 18'h0F0F1, 2'b00, 1'b0});
      check("R8", "idle after write sampled", {17'b0, idle}, 18'd0);
      issue(NOP);
      check("R8", "idle after commit", {17'b0, idle}, 18'd1);
      issue('{1'b1, 4'd9, 1'b0, 4'd0, 18'h0, 2'b00, 18'h0, 2'b00, 1'b0}); // R5 R11
      repeat (4) issue(NOP);

      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

endmodule